// File: doc/BRIEF.md
# Issue interlock latency scoreboard

This block sits at the issue stage of an in-order integer pipeline. Each cycle it decides whether the instruction at issue may enter execute, or must stall because an older instruction is still producing one of its source registers. Each instruction comes with a class code, an optional destination register and up to three source registers. Every source is tagged with a role: a late operand, or an early operand that feeds a shift, an address or a multiplier.

The block keeps one countdown counter per architectural register. When an instruction issues and writes a register, that register's counter is loaded from the producer's class latency. The counter then drains by one every cycle. Each source is checked against its counter, with one cycle of slack for late operands. Branch sources are a special case: they get the slack only when the producer class allows it.

A second counter models classes that hold the first execute stage for extra cycles. While that counter is non-zero, nothing issues. When a stall occurs, the upstream logic holds the instruction unchanged. When there is no stall, the instruction issues in the same cycle.

Top module: `issue_scoreboard`

## Requirements
- R1: `issue_o` is high exactly when `valid_i` is high and `stall_o` is low. `stall_o` is never high while `valid_i` is low.
- R2: The plain ALU class (code 0) and the constant-shift ALU class (code 1) have latency 2. An early consumer issued right behind one waits 2 cycles from the producer's issue.
- R3: The register-shift ALU class (code 2) has latency 3. It also blocks any issue in the cycle directly after its own issue.
- R4: The multiply classes have these latencies: 32-bit product (code 3) 4, 64-bit product (code 4) 5, single-pass half-word (code 5) 3, half-word with 64-bit accumulate (code 6) 4, high-word product (code 7) 4. Codes 3, 6 and 7 block issue for 1 cycle after issue, code 4 for 2 cycles, and code 5 not at all.
- R5: Latencies for loads are 3 for word or doubleword (code 8), 4 for byte (code 9) and 4 for three or more registers (code 10). A store (code 11) and a branch (code 12) never delay any consumer, even when their destination enable is high.
- R6: A non-branch source with role code 0 (late) waits one cycle less than the producer latency. Role codes 1 (shift), 2 (address) and 3 (multiplier) wait the full latency.
- R7: Every source of a branch (code 12) waits one cycle less than the latency when the producer is code 0, 1, 2, 8 or 10, and the full latency for any other producer.
- R8: A call (code 13) has latency 32.
- R9: A newer write to a register replaces its count, even when the new count is shorter. Register 0 behaves like any other register.
- R10: After reset every register is ready and no issue block is pending.
- R11: A source whose enable is low is never checked. A producer whose destination enable is low leaves the register counts unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| valid_i | input | 1 | An instruction is waiting at issue |
| class_i | input | 4 | Class code of the waiting instruction |
| dst_en_i | input | 1 | Instruction writes a destination |
| dst_idx_i | input | IDX_W | Destination register index |
| src_en_i | input | NUM_SRC | Per-source enable |
| src_idx_i | input | NUM_SRC*IDX_W | Packed source indices, source 0 in the low bits |
| src_role_i | input | NUM_SRC*2 | Packed 2-bit role codes, source 0 in the low bits |
| stall_o | output | 1 | Waiting instruction must be held |
| issue_o | output | 1 | Waiting instruction enters execute this cycle |

## Verification
The bench measures the issue gap for every producer class against early, late and branch consumers. A scoreboard that loads the counter with the raw latency would show every gap one cycle too long. A scoreboard that ignored roles would make late consumers wait the full latency. It also covers the cases where a branch does not get the early slot after a multiply or a byte load, where a short write overwrites a pending call on the same register, and where a multiply or register-shift op blocks unrelated instructions. A long random stream over four registers compares every stall decision with a timestamp model, which catches slips in counter saturation and in clearing the issue block.

// File: rtl/sb_pkg.sv
package sb_pkg;
  localparam int LAT_W  = 6;
  localparam int HOLD_W = 2;
  localparam int CALL_LAT = 32;

  typedef enum logic [3:0] {
    CLS_ALU         = 4'd0,
    CLS_ALU_SHC     = 4'd1,
    CLS_ALU_SHR     = 4'd2,
    CLS_MUL32       = 4'd3,
    CLS_MUL64       = 4'd4,
    CLS_MUL16       = 4'd5,
    CLS_MUL16_ACC64 = 4'd6,
    CLS_MUL_MSW     = 4'd7,
    CLS_LD_WORD     = 4'd8,
    CLS_LD_BYTE     = 4'd9,
    CLS_LD_MULTI    = 4'd10,
    CLS_STORE       = 4'd11,
    CLS_BRANCH      = 4'd12,
    CLS_CALL        = 4'd13
  } cls_e;

  typedef enum logic [1:0] {
    ROLE_LATE  = 2'd0,
    ROLE_SHIFT = 2'd1,
    ROLE_ADDR  = 2'd2,
    ROLE_MUL   = 2'd3
  } role_e;

  typedef struct packed {
    logic [LAT_W-1:0]  lat;
    logic              br_fast;
    logic [HOLD_W-1:0] hold;
  } cls_info_t;
endpackage

// File: rtl/sb_lat_table.sv
module sb_lat_table
  import sb_pkg::*;
(
  input  logic [3:0] cls_i,
  output cls_info_t  info_o
);
  always_comb begin
    info_o = '{lat: LAT_W'(2), br_fast: 1'b1, hold: '0};
    case (cls_e'(cls_i))
      CLS_ALU, CLS_ALU_SHC: info_o = '{lat: LAT_W'(2), br_fast: 1'b1, hold: HOLD_W'(0)};
      CLS_ALU_SHR:          info_o = '{lat: LAT_W'(3), br_fast: 1'b1, hold: HOLD_W'(1)};
      CLS_MUL32:            info_o = '{lat: LAT_W'(4), br_fast: 1'b0, hold: HOLD_W'(1)};
      CLS_MUL64:            info_o = '{lat: LAT_W'(5), br_fast: 1'b0, hold: HOLD_W'(2)};
      CLS_MUL16:            info_o = '{lat: LAT_W'(3), br_fast: 1'b0, hold: HOLD_W'(0)};
      CLS_MUL16_ACC64:      info_o = '{lat: LAT_W'(4), br_fast: 1'b0, hold: HOLD_W'(1)};
      CLS_MUL_MSW:          info_o = '{lat: LAT_W'(4), br_fast: 1'b0, hold: HOLD_W'(1)};
      CLS_LD_WORD:          info_o = '{lat: LAT_W'(3), br_fast: 1'b1, hold: HOLD_W'(0)};
      CLS_LD_BYTE:          info_o = '{lat: LAT_W'(4), br_fast: 1'b0, hold: HOLD_W'(0)};
      CLS_LD_MULTI:         info_o = '{lat: LAT_W'(4), br_fast: 1'b1, hold: HOLD_W'(0)};
      CLS_STORE, CLS_BRANCH: info_o = '{lat: LAT_W'(0), br_fast: 1'b0, hold: HOLD_W'(0)};
      CLS_CALL:             info_o = '{lat: LAT_W'(CALL_LAT), br_fast: 1'b0, hold: HOLD_W'(0)};
      default:              info_o = '{lat: LAT_W'(2), br_fast: 1'b1, hold: HOLD_W'(0)};
    endcase
  end
endmodule

// File: rtl/sb_cnt_bank.sv
module sb_cnt_bank #(
  parameter  int NUM_REGS = 16,
  parameter  int CNT_W    = 6,
  localparam int IDX_W    = $clog2(NUM_REGS)
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             wr_en_i,
  input  logic [IDX_W-1:0] wr_idx_i,
  input  logic [CNT_W-1:0] wr_cnt_i,
  input  logic             wr_fast_i,
  output logic [CNT_W-1:0] cnt_o  [NUM_REGS],
  output logic             fast_o [NUM_REGS]
);
  for (genvar r = 0; r < NUM_REGS; r++) begin : g_reg
    logic hit;
    assign hit = wr_en_i && (wr_idx_i == IDX_W'(r));
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
        cnt_o[r]  <= '0;
        fast_o[r] <= 1'b0;
      end else if (hit) begin
        cnt_o[r]  <= wr_cnt_i;
        fast_o[r] <= wr_fast_i;
      end else if (cnt_o[r] != '0) begin
        cnt_o[r]  <= cnt_o[r] - 1'b1;
      end
    end
  end
endmodule

// File: rtl/sb_src_check.sv
module sb_src_check
  import sb_pkg::*;
#(
  parameter  int NUM_REGS = 16,
  parameter  int CNT_W    = 6,
  localparam int IDX_W    = $clog2(NUM_REGS)
) (
  input  logic             en_i,
  input  logic [IDX_W-1:0] idx_i,
  input  logic [1:0]       role_i,
  input  logic             branch_i,
  input  logic [CNT_W-1:0] cnt_i  [NUM_REGS],
  input  logic             fast_i [NUM_REGS],
  output logic             ready_o
);
  logic [CNT_W-1:0] cnt;
  logic             slack;
  always_comb begin
    cnt   = cnt_i[idx_i];
    // branches take slack from the producer, others from their own role
    slack = branch_i ? fast_i[idx_i] : (role_e'(role_i) == ROLE_LATE);
    ready_o = !en_i || (cnt == '0) || (slack && cnt == CNT_W'(1));
  end
endmodule

// File: rtl/sb_hold_ctr.sv
module sb_hold_ctr #(
  parameter int HOLD_W = 2
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              issue_i,
  input  logic [HOLD_W-1:0] hold_i,
  output logic              busy_o
);
  logic [HOLD_W-1:0] cnt_q;
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)              cnt_q <= '0;
    else if (issue_i)         cnt_q <= hold_i;
    else if (cnt_q != '0)     cnt_q <= cnt_q - 1'b1;
  end
  assign busy_o = (cnt_q != '0);
endmodule

// File: rtl/issue_scoreboard.sv
module issue_scoreboard
  import sb_pkg::*;
#(
  parameter  int NUM_REGS = 16,
  parameter  int NUM_SRC  = 3,
  localparam int IDX_W    = $clog2(NUM_REGS),
  localparam int CNT_W    = LAT_W
) (
  input  logic                     clk_i,
  input  logic                     rst_ni,
  input  logic                     valid_i,
  input  logic [3:0]               class_i,
  input  logic                     dst_en_i,
  input  logic [IDX_W-1:0]         dst_idx_i,
  input  logic [NUM_SRC-1:0]       src_en_i,
  input  logic [NUM_SRC*IDX_W-1:0] src_idx_i,
  input  logic [NUM_SRC*2-1:0]     src_role_i,
  output logic                     stall_o,
  output logic                     issue_o
);
  cls_info_t        info;
  logic [CNT_W-1:0] cnt_q  [NUM_REGS];
  logic             fast_q [NUM_REGS];
  logic [NUM_SRC-1:0] src_ready;
  logic             busy;
  logic             is_branch;
  logic             wr_en;
  logic [CNT_W-1:0] wr_cnt;

  sb_lat_table u_tab (.cls_i(class_i), .info_o(info));

  assign is_branch = (cls_e'(class_i) == CLS_BRANCH);

  for (genvar s = 0; s < NUM_SRC; s++) begin : g_src
    sb_src_check #(.NUM_REGS(NUM_REGS), .CNT_W(CNT_W)) u_chk (
      .en_i    (src_en_i[s]),
      .idx_i   (src_idx_i[s*IDX_W +: IDX_W]),
      .role_i  (src_role_i[s*2 +: 2]),
      .branch_i(is_branch),
      .cnt_i   (cnt_q),
      .fast_i  (fast_q),
      .ready_o (src_ready[s])
    );
  end

  sb_hold_ctr #(.HOLD_W(HOLD_W)) u_hold (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .issue_i(issue_o),
    .hold_i (info.hold),
    .busy_o (busy)
  );

  assign stall_o = valid_i && (busy || !(&src_ready));
  assign issue_o = valid_i && !stall_o;

  // counter holds cycles left until an early consumer may issue
  assign wr_en  = issue_o && dst_en_i && (info.lat != '0);
  assign wr_cnt = info.lat - 1'b1;

  sb_cnt_bank #(.NUM_REGS(NUM_REGS), .CNT_W(CNT_W)) u_bank (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .wr_en_i  (wr_en),
    .wr_idx_i (dst_idx_i),
    .wr_cnt_i (wr_cnt),
    .wr_fast_i(info.br_fast),
    .cnt_o    (cnt_q),
    .fast_o   (fast_q)
  );
endmodule

// File: rtl/sb_checker.sv
module sb_checker
  import sb_pkg::*;
#(
  parameter  int NUM_REGS = 16,
  parameter  int CNT_W    = 6,
  localparam int IDX_W    = $clog2(NUM_REGS)
) (
  input logic             clk_i,
  input logic             rst_ni,
  input logic             valid_i,
  input logic [3:0]       class_i,
  input logic             dst_en_i,
  input logic [IDX_W-1:0] dst_idx_i,
  input logic             stall_o,
  input logic             issue_o,
  input logic [CNT_W-1:0] cnt_q [NUM_REGS]
);
  AST_NO_STALL_IDLE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !valid_i |-> !stall_o && !issue_o); // R1
  AST_ISSUE_EXCL: assert property (@(posedge clk_i) disable iff (!rst_ni)
    valid_i |-> (issue_o != stall_o)); // R1
  AST_ALU_LOAD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    issue_o && dst_en_i && cls_e'(class_i) == CLS_ALU |=> cnt_q[$past(dst_idx_i)] == CNT_W'(1)); // R2
  AST_SHR_SLIP: assert property (@(posedge clk_i) disable iff (!rst_ni)
    issue_o && cls_e'(class_i) == CLS_ALU_SHR |=> !issue_o); // R3
  AST_MUL64_SLIP: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $past(rst_ni, 2) && $past(issue_o, 2) && cls_e'($past(class_i, 2)) == CLS_MUL64 |-> !issue_o); // R4
  AST_STORE_NOWRITE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    issue_o && cls_e'(class_i) == CLS_STORE && dst_en_i && cnt_q[dst_idx_i] == '0
    |=> cnt_q[$past(dst_idx_i)] == '0); // R5
endmodule

bind issue_scoreboard sb_checker #(.NUM_REGS(NUM_REGS), .CNT_W(CNT_W)) u_sb_checker (
  .clk_i    (clk_i),
  .rst_ni   (rst_ni),
  .valid_i  (valid_i),
  .class_i  (class_i),
  .dst_en_i (dst_en_i),
  .dst_idx_i(dst_idx_i),
  .stall_o  (stall_o),
  .issue_o  (issue_o),
  .cnt_q    (cnt_q)
);

// File: tb/issue_scoreboard_bench.sv
module issue_scoreboard_bench;
  localparam int NR = 16;
  localparam int NS = 3;
  localparam int IW = 4;

  logic          clk = 1'b0;
  logic          rst_ni = 1'b0;
  logic          valid_i = 1'b0;
  logic [3:0]    class_i = '0;
  logic          dst_en_i = 1'b0;
  logic [IW-1:0] dst_idx_i = '0;
  logic [NS-1:0] src_en_i = '0;
  logic [NS*IW-1:0] src_idx_i = '0;
  logic [NS*2-1:0]  src_role_i = '0;
  logic stall_o, issue_o;

  int total = 0;
  int bad = 0;
  bit done = 1'b0;

  always #2 clk = ~clk;

  issue_scoreboard #(.NUM_REGS(NR), .NUM_SRC(NS)) u_issue_scoreboard (
    .clk_i(clk), .rst_ni(rst_ni), .valid_i(valid_i), .class_i(class_i),
    .dst_en_i(dst_en_i), .dst_idx_i(dst_idx_i), .src_en_i(src_en_i),
    .src_idx_i(src_idx_i), .src_role_i(src_role_i),
    .stall_o(stall_o), .issue_o(issue_o));

  function automatic int lat_of(int c);
    case (c)
      0, 1: return 2;
      2: return 3;
      3: return 4;
      4: return 5;
      5: return 3;
      6, 7: return 4;
      8: return 3;
      9, 10: return 4;
      11, 12: return 0;
      13: return 32;
      default: return 2;
    endcase
  endfunction
  function automatic bit fast_of(int c);
    return (c == 0 || c == 1 || c == 2 || c == 8 || c == 10 || c > 13);
  endfunction
  function automatic int hold_of(int c);
    case (c)
      2, 3, 6, 7: return 1;
      4: return 2;
      default: return 0;
    endcase
  endfunction

  task automatic chk(bit ok, string tag, int act, int exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  task automatic idle(int n);
    for (int i = 0; i < n; i++) begin
      @(negedge clk);
      valid_i = 1'b0; src_en_i = '0; dst_en_i = 1'b0;
    end
  endtask

  // producer then consumer on register pd; returns cycles from producer issue to consumer issue
  task automatic run_pair(int pc, bit pden, int pd, int cc, bit sen, int role, string tag, int exp);
    int gap;
    idle(40);
    @(negedge clk);
    valid_i = 1'b1; class_i = 4'(pc); dst_en_i = pden; dst_idx_i = IW'(pd); src_en_i = '0;
    #1;
    if (!issue_o) chk(1'b0, {tag, " producer issue"}, 0, 1);
    @(negedge clk);
    class_i = 4'(cc); dst_en_i = 1'b0;
    src_en_i = {2'b00, sen}; src_idx_i = (NS*IW)'(pd); src_role_i = (NS*2)'(role);
    gap = 1;
    #1;
    while (!issue_o && gap < 80) begin
      @(negedge clk); #1; gap++;
    end
    @(negedge clk);
    valid_i = 1'b0; src_en_i = '0;
    chk(gap == exp, tag, gap, exp);
  endtask

  task automatic random_stream(int n);
    int rdy [NR];
    bit rfast [NR];
    int busy_until;
    int now;
    bit held;
    int c;
    bit ok, exp_stall, exp_issue, v;
    for (int r = 0; r < NR; r++) begin rdy[r] = 0; rfast[r] = 1'b0; end
    busy_until = 0; now = 0; held = 1'b0; c = 0; v = 1'b0;
    for (int k = 0; k < n; k++) begin
      @(negedge clk);
      if (!held) begin
        v = ($urandom_range(0, 9) < 8);
        c = $urandom_range(0, 13);
        if ($urandom_range(0, 19) == 0) c = 13; else if (c == 13) c = 0;
        valid_i = v; class_i = 4'(c);
        dst_en_i = $urandom_range(0, 3) != 0;
        dst_idx_i = IW'($urandom_range(0, 3));
        for (int s = 0; s < NS; s++) begin
          src_en_i[s] = $urandom_range(0, 1);
          src_idx_i[s*IW +: IW] = IW'($urandom_range(0, 3));
          src_role_i[s*2 +: 2] = 2'($urandom_range(0, 3));
        end
      end
      #1;
      ok = 1'b1;
      for (int s = 0; s < NS; s++) begin
        if (src_en_i[s]) begin
          int r;
          int slack;
          r = int'(src_idx_i[s*IW +: IW]);
          slack = (c == 12) ? int'(rfast[r]) : int'(src_role_i[s*2 +: 2] == 2'd0);
          if (now < rdy[r] - slack) ok = 1'b0;
        end
      end
      exp_stall = v && (now < busy_until || !ok);
      exp_issue = v && !exp_stall;
      chk(stall_o == exp_stall, "R1 random stall", int'(stall_o), int'(exp_stall));
      chk(issue_o == exp_issue, "R1 random issue", int'(issue_o), int'(exp_issue));
      if (exp_issue) begin
        busy_until = now + 1 + hold_of(c);
        if (dst_en_i && lat_of(c) > 0) begin
          rdy[int'(dst_idx_i)] = now + lat_of(c);
          rfast[int'(dst_idx_i)] = fast_of(c);
        end
      end
      held = exp_stall;
      now++;
    end
    idle(1);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_ni = 1'b1;
    @(negedge clk); #1;
    chk(stall_o == 1'b0 && issue_o == 1'b0, "R10 idle after reset", int'(stall_o), 0);
    @(negedge clk);
    valid_i = 1'b1; class_i = 4'd3; src_en_i = '1;
    src_idx_i = {4'd0, 4'd7, 4'd15}; src_role_i = {2'd3, 2'd2, 2'd1};
    #1;
    chk(issue_o == 1'b1, "R10 all ready after reset", int'(issue_o), 1);
    idle(3);

    random_stream(4000);

    run_pair(0, 1, 0, 0, 1, 1, "R2 alu->shift", 2);
    run_pair(1, 1, 3, 0, 1, 2, "R2 alu_shc->addr", 2);
    run_pair(0, 1, 3, 0, 1, 0, "R2 R6 alu->late", 1);
    run_pair(2, 1, 4, 3, 1, 3, "R3 shr->mul", 3);
    run_pair(2, 1, 4, 0, 1, 0, "R3 shr->late", 2);
    run_pair(2, 1, 4, 0, 0, 1, "R3 shr slip", 2);
    run_pair(3, 1, 5, 3, 1, 3, "R4 mul32", 4);
    run_pair(4, 1, 5, 3, 1, 3, "R4 mul64", 5);
    run_pair(4, 1, 5, 0, 0, 1, "R4 mul64 slip", 3);
    run_pair(5, 1, 5, 3, 1, 3, "R4 mul16", 3);
    run_pair(5, 1, 5, 0, 0, 1, "R4 mul16 no slip", 1);
    run_pair(6, 1, 6, 0, 1, 1, "R4 mul16acc64", 4);
    run_pair(7, 1, 6, 0, 1, 2, "R4 msw", 4);
    run_pair(8, 1, 7, 11, 1, 2, "R5 ldword->addr", 3);
    run_pair(9, 1, 7, 0, 1, 1, "R5 ldbyte", 4);
    run_pair(10, 1, 7, 0, 1, 1, "R5 ldmulti", 4);
    run_pair(11, 1, 7, 0, 1, 1, "R5 store nowrite", 1);
    run_pair(12, 1, 7, 0, 1, 1, "R5 branch nowrite", 1);
    run_pair(9, 1, 8, 0, 1, 0, "R6 ldbyte->late", 3);
    run_pair(3, 1, 8, 0, 1, 0, "R6 mul32->late", 3);
    run_pair(0, 1, 9, 12, 1, 1, "R7 alu->branch", 1);
    run_pair(2, 1, 9, 12, 1, 1, "R7 shr->branch", 2);
    run_pair(8, 1, 9, 12, 1, 1, "R7 ldword->branch", 2);
    run_pair(10, 1, 9, 12, 1, 1, "R7 ldmulti->branch", 3);
    run_pair(3, 1, 9, 12, 1, 0, "R7 mul32->branch", 4);
    run_pair(9, 1, 9, 12, 1, 0, "R7 ldbyte->branch", 4);
    run_pair(13, 1, 14, 0, 1, 2, "R8 call->addr", 32);
    run_pair(13, 1, 14, 0, 1, 0, "R8 call->late", 31);
    run_pair(4, 0, 2, 3, 1, 3, "R11 no dst", 3);
    run_pair(4, 1, 2, 3, 0, 3, "R11 src disabled", 3);

    // R9: a call then a shorter ALU write to register 0
    begin
      int gap;
      idle(40);
      @(negedge clk);
      valid_i = 1'b1; class_i = 4'd13; dst_en_i = 1'b1; dst_idx_i = '0; src_en_i = '0;
      @(negedge clk);
      class_i = 4'd0;
      #1;
      chk(issue_o == 1'b1, "R9 overwrite issue", int'(issue_o), 1);
      @(negedge clk);
      dst_en_i = 1'b0; src_en_i = 3'b001; src_idx_i = '0; src_role_i = 6'd1;
      gap = 1;
      #1;
      while (!issue_o && gap < 80) begin @(negedge clk); #1; gap++; end
      chk(gap == 2, "R9 overwrite shorter", gap, 2);
      idle(1);
    end

    done = 1'b1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      total++; bad++;
      $display("FAIL watchdog actual=%0d expected=%0d", 0, 1);
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end
endmodule